// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits beside an outbound DMA engine and classifies each address the engine is about to issue. It holds four programmable windows, and each window names a target unit and an attribute byte. When a request arrives, the block compares the upper half of the 32-bit address against every enabled window. One cycle later it reports whether a window matched, which one, and that window's target identifier and attribute. The bus fabric uses the target and attribute to route the access.

Software programs the windows through a small register port. Each window has two words. The control word packs an enable bit, a 4-bit target, an 8-bit attribute and the window size minus one, counted in 64 KB units. The base word carries the 64 KB-aligned start address. A window's size field works as a mask of address bits that are not compared. With sizes of the form 2^k units, a window covers an aligned power-of-two region. When windows overlap, the lowest-numbered one wins. Register writes go to storage and do not stall requests.

Top module: `dma_addr_window_dec`

## Requirements
- R1: After reset every window is disabled and all its stored fields are zero. Every register reads as zero, and rsp_valid, rsp_hit and rsp_miss are low.
- R2: Window n (n = 0..3) has its control word at register address 0x30 + 16·n and its base word at 0x34 + 16·n. In the control word, bit 0 is enable, bits [7:4] are the target, bits [15:8] are the attribute and bits [31:16] are size minus one. In the base word, bits [31:16] are the base. A read returns the last written value, except that control bits [3:1] and base bits [15:0] read as zero.
- R3: A write to any register address outside those eight words changes nothing, and a read of such an address returns zero.
- R4: A request with address A hits window n when the window is enabled and A[31:16] and base[31:16] agree on every bit that is clear in the size field. Address bits [15:0] never take part in the match.
- R5: A window whose enable bit is zero never hits. Writing zero to both of its words disables it.
- R6: When more than one window hits, the result reports the lowest-numbered one.
- R7: When no window hits, rsp_miss is high, rsp_hit is low, and rsp_win, rsp_target and rsp_attr are zero.
- R8: rsp_valid is high exactly in the cycle after a cycle with req_valid high. While rsp_valid is low, rsp_hit, rsp_miss, rsp_win, rsp_target and rsp_attr are all zero.
- R9: On a hit, rsp_win gives the window number, and rsp_target and rsp_attr give that window's target and attribute fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| req_valid | input | 1 | Decode request valid |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Decode result valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 2 | Number of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |

## Verification
The hardest case to reach is an overlap. In it, a higher-numbered window would match on its own but must lose to a lower one, and it must win again once the lower one is cleared by zero writes. The stimulus programs window 1 inside window 0's range and sweeps addresses across the shared region. It then zeroes window 0 and repeats the sweep. Masked base bits that differ from the address are covered by a window whose stored base is deliberately unaligned to its size. Every sweep also walks the edges of each window: the first and last matching upper-address values and their outside neighbours.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;

    localparam int HALF_W = 16;
    localparam int TGT_W  = 4;
    localparam int ATTR_W = 8;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [HALF_W-1:0] size_m1;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  tgt;
        logic              en;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
    } win_sel_t;

    function automatic logic [WORD_W-1:0] ctrl_to_word(input win_cfg_t c);
        return {c.size_m1, c.attr, c.tgt, 3'b000, c.en};
    endfunction

    function automatic win_cfg_t word_to_ctrl(input logic [WORD_W-1:0] w);
        win_cfg_t c;
        c.size_m1 = w[31:16];
        c.attr    = w[15:8];
        c.tgt     = w[7:4];
        c.en      = w[0];
        return c;
    endfunction

    function automatic logic window_hits(input logic              en,
                                         input logic [HALF_W-1:0] size_m1,
                                         input logic [HALF_W-1:0] base_hi,
                                         input logic [HALF_W-1:0] addr_hi);
        return en && ((addr_hi & ~size_m1) == (base_hi & ~size_m1));
    endfunction

endpackage

// File: rtl/dma_win_regs.sv
module dma_win_regs
    import dma_win_pkg::*;
#(
    parameter int NUM_WIN    = 4,
    parameter int REG_ADDR_W = 8,
    parameter int CTRL_BASE  = 48,
    parameter int BASE_DELTA = 4,
    parameter int WIN_STRIDE = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [REG_ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    output logic [WORD_W-1:0]     cfg_rdata,
    output win_cfg_t              cfg_q  [NUM_WIN],
    output logic [HALF_W-1:0]     base_q [NUM_WIN]
);

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[3:1], cfg_wdata[HALF_W-1:0]};

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam int CTRL_OFS = CTRL_BASE + g * WIN_STRIDE;
        localparam int BASE_OFS = CTRL_OFS + BASE_DELTA;

        logic wr_ctrl, wr_base;
        assign wr_ctrl = cfg_we && (cfg_addr == REG_ADDR_W'(CTRL_OFS));
        assign wr_base = cfg_we && (cfg_addr == REG_ADDR_W'(BASE_OFS));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g]  <= '0;
                base_q[g] <= '0;
            end else begin
                if (wr_ctrl) cfg_q[g]  <= word_to_ctrl(cfg_wdata);
                if (wr_base) base_q[g] <= cfg_wdata[WORD_W-1:HALF_W];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg_addr == REG_ADDR_W'(CTRL_BASE + i * WIN_STRIDE))
                cfg_rdata = ctrl_to_word(cfg_q[i]);
            if (cfg_addr == REG_ADDR_W'(CTRL_BASE + i * WIN_STRIDE + BASE_DELTA))
                cfg_rdata = {base_q[i], {HALF_W{1'b0}}};
        end
    end

endmodule

// File: rtl/dma_win_match.sv
module dma_win_match
    import dma_win_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  win_cfg_t          cfg_q  [NUM_WIN],
    input  logic [HALF_W-1:0] base_q [NUM_WIN],
    input  logic [HALF_W-1:0] addr_hi,
    output logic [NUM_WIN-1:0] hit_vec
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic unused_fields;
        assign unused_fields = ^{cfg_q[g].attr, cfg_q[g].tgt};
        assign hit_vec[g] = window_hits(cfg_q[g].en, cfg_q[g].size_m1,
                                        base_q[g], addr_hi);
    end

endmodule

// File: rtl/dma_win_prio.sv
module dma_win_prio
    import dma_win_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    input  win_cfg_t           cfg_q [NUM_WIN],
    output win_sel_t           sel,
    output logic [IDX_W-1:0]   sel_idx
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_sink
        logic unused_fields;
        assign unused_fields = ^{cfg_q[g].size_m1, cfg_q[g].en};
    end

    // Scan from the top down so the lowest-numbered hit is assigned last.
    always_comb begin
        sel     = '0;
        sel_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel.hit  = 1'b1;
                sel.tgt  = cfg_q[i].tgt;
                sel.attr = cfg_q[i].attr;
                sel_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_addr_window_dec.sv
module dma_addr_window_dec
    import dma_win_pkg::*;
#(
    parameter int NUM_WIN    = 4,
    parameter int REG_ADDR_W = 8,
    parameter int CTRL_BASE  = 48,
    parameter int BASE_DELTA = 4,
    parameter int WIN_STRIDE = 16,
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [REG_ADDR_W-1:0] cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  req_valid,
    input  logic [31:0]           req_addr,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic [IDX_W-1:0]      rsp_win,
    output logic [3:0]            rsp_target,
    output logic [7:0]            rsp_attr
);

    win_cfg_t           cfg_q  [NUM_WIN];
    logic [HALF_W-1:0]  base_q [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    win_sel_t           sel;
    logic [IDX_W-1:0]   sel_idx;

    logic unused_low_addr;
    assign unused_low_addr = ^req_addr[HALF_W-1:0];

    dma_win_regs #(
        .NUM_WIN   (NUM_WIN),
        .REG_ADDR_W(REG_ADDR_W),
        .CTRL_BASE (CTRL_BASE),
        .BASE_DELTA(BASE_DELTA),
        .WIN_STRIDE(WIN_STRIDE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .cfg_q    (cfg_q),
        .base_q   (base_q)
    );

    dma_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg_q  (cfg_q),
        .base_q (base_q),
        .addr_hi(req_addr[31:HALF_W]),
        .hit_vec(hit_vec)
    );

    dma_win_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
        .hit_vec(hit_vec),
        .cfg_q  (cfg_q),
        .sel    (sel),
        .sel_idx(sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_win    <= '0;
            rsp_target <= '0;
            rsp_attr   <= '0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= sel.hit;
            rsp_miss   <= !sel.hit;
            rsp_win    <= sel.hit ? sel_idx : '0;
            rsp_target <= sel.hit ? sel.tgt : '0;
            rsp_attr   <= sel.hit ? sel.attr : '0;
        end
    end

endmodule

// File: rtl/dma_win_chk.sv
module dma_win_chk #(
    parameter int REG_ADDR_W = 8,
    parameter int IDX_W      = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [REG_ADDR_W-1:0] cfg_addr,
    input logic [31:0]           cfg_rdata,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic                  rsp_miss,
    input logic [IDX_W-1:0]      rsp_win,
    input logic [3:0]            rsp_target,
    input logic [7:0]            rsp_attr
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_valid && !rsp_hit && !rsp_miss));

    assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[3:0] == 4'h0) |-> (cfg_rdata[3:1] == 3'b000));

    assert_base_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[3:0] == 4'h4) |-> (cfg_rdata[15:0] == 16'h0000));

    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_win == '0 && rsp_target == 4'h0 && rsp_attr == 8'h00));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_win == '0
                        && rsp_target == 4'h0 && rsp_attr == 8'h00));

endmodule

bind dma_addr_window_dec dma_win_chk #(
    .REG_ADDR_W(REG_ADDR_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_win   (rsp_win),
    .rsp_target(rsp_target),
    .rsp_attr  (rsp_attr)
);

// File: tb/sim_dma_addr_window_dec.sv
module sim_dma_addr_window_dec;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [1:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench-side copy of what was written, by window
    logic [31:0] m_ctrl [4];
    logic [31:0] m_base [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_window_dec u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        int w;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h30 && a < 8'h70 && (a[3:0] == 4'h0 || a[3:0] == 4'h4)) begin
            w = (int'(a) - 48) / 16;
            if (a[3:0] == 4'h0) m_ctrl[w] = d; else m_base[w] = d;
        end
    endtask

    task automatic reg_read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    // Expected {valid, hit, miss, win, target, attr} as a 17-bit value
    function automatic logic [16:0] expect_of(input logic [31:0] a);
        logic [15:0] ahi, bhi, sz;
        for (int i = 0; i < 4; i++) begin
            ahi = a[31:16];
            bhi = m_base[i][31:16];
            sz  = m_ctrl[i][31:16];
            if (m_ctrl[i][0] && (((ahi ^ bhi) & ~sz) == 16'h0))
                return {1'b1, 1'b1, 1'b0, 2'(i), m_ctrl[i][7:4], m_ctrl[i][15:8]};
        end
        return {1'b1, 1'b0, 1'b1, 2'b00, 4'h0, 8'h00};
    endfunction

    task automatic decode_check(input logic [31:0] a);
        logic [16:0] e;
        string tag;
        e = expect_of(a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        tag = e[15] ? "R4 R6 R9 hit" : "R5 R7 miss";
        check(tag, {15'h0, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr},
              {15'h0, e});
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R8 idle", {15'h0, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr}, 32'h0);
    endtask

    task automatic sweep();
        logic [15:0] lo, hi, bhi, sz;
        for (int i = 0; i < 4096; i++) begin
            logic [15:0] ahi;
            ahi = {i[11:0], i[3:0]};
            decode_check({ahi, 16'(i * 16'h9E37)});
        end
        for (int w = 0; w < 4; w++) begin
            bhi = m_base[w][31:16];
            sz  = m_ctrl[w][31:16];
            lo  = bhi & ~sz;
            hi  = lo | sz;
            decode_check({lo - 16'h1, 16'hFFFF});
            decode_check({lo, 16'h0000});
            decode_check({hi, 16'hFFFF});
            decode_check({hi + 16'h1, 16'h0000});
        end
        idle_check();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_ctrl[i] = 0; m_base[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        check("R1 rsp flags after reset", {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h0);
        for (int w = 0; w < 4; w++) begin
            reg_read_check(8'(48 + 16*w), 32'h0, "R1 ctrl reset");
            reg_read_check(8'(52 + 16*w), 32'h0, "R1 base reset");
        end
        sweep();   // R1/R7: everything misses

        // Config B: overlap, disabled window, junk in padding bits (R2 R5 R6 R9)
        reg_write(8'h30, {16'h00FF, 8'h5A, 4'h3, 3'b111, 1'b1});
        reg_write(8'h34, 32'h1000_ABCD);
        reg_write(8'h40, {16'h000F, 8'hC3, 4'h7, 3'b101, 1'b1});
        reg_write(8'h44, 32'h1080_1234);
        reg_write(8'h50, {16'h7FFF, 8'h11, 4'hA, 3'b010, 1'b1});
        reg_write(8'h54, 32'h8000_FFFF);
        reg_write(8'h60, {16'h0000, 8'hEE, 4'h1, 3'b000, 1'b0});
        reg_write(8'h64, 32'h4000_0001);
        for (int w = 0; w < 4; w++) begin
            reg_read_check(8'(48 + 16*w), m_ctrl[w] & 32'hFFFF_FFF1, "R2 ctrl readback");
            reg_read_check(8'(52 + 16*w), m_base[w] & 32'hFFFF_0000, "R2 base readback");
        end
        sweep();
        // R6: address in both windows 0 and 1 reports window 0
        decode_check(32'h1085_0000);
        check("R6 overlap picks window 0", {30'h0, rsp_win}, 32'h0);

        // Config C: zero window 0 (R5), unaligned base under mask on window 3 (R4)
        reg_write(8'h30, 32'h0);
        reg_write(8'h34, 32'h0);
        reg_write(8'h60, {16'h000F, 8'hEE, 4'h1, 3'b000, 1'b1});
        reg_write(8'h64, 32'h4003_0000);
        sweep();
        decode_check(32'h1085_0000);
        check("R5 zeroed window 0 lets window 1 win", {30'h0, rsp_win}, 32'h1);
        decode_check(32'h400F_0000);
        check("R4 masked base bits ignored", {31'h0, rsp_hit}, 32'h1);

        // Config D: unmapped addresses ignored (R3)
        reg_write(8'h38, 32'hFFFF_FFFF);
        reg_write(8'h20, 32'hFFFF_FFFF);
        reg_write(8'h74, 32'hFFFF_FFFF);
        reg_write(8'h31, 32'hFFFF_FFFF);
        reg_read_check(8'h38, 32'h0, "R3 unmapped read");
        reg_read_check(8'h20, 32'h0, "R3 unmapped read");
        reg_read_check(8'h74, 32'h0, "R3 unmapped read");
        reg_read_check(8'h31, 32'h0, "R3 unmapped read");
        for (int w = 0; w < 4; w++) begin
            reg_read_check(8'(48 + 16*w), m_ctrl[w] & 32'hFFFF_FFF1, "R3 ctrl unchanged");
            reg_read_check(8'(52 + 16*w), m_base[w] & 32'hFFFF_0000, "R3 base unchanged");
        end
        sweep();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule